// File: doc/BRIEF.md
# Two-Stage Interrupt Flag Aggregator

This block turns a bank of peripheral event flags into a vector of interrupt requests for a processor core. A flag is set by a one-cycle hardware event pulse or by software, and it is cleared by software. Each flag has its own enable bit. The enabled flags that belong to one line are OR-reduced into a level signal for that line. Each line owns `FLAGS_PER_LINE` consecutive flags: line `i` owns flags `i*FLAGS_PER_LINE` to `i*FLAGS_PER_LINE+FLAGS_PER_LINE-1`.

The controller stage has one pending bit per line. A high line level latches the pending bit. Software can also set or clear it, and a one-hot acknowledge from the core clears it. A pending bit reaches the core only while the line's controller enable bit is set. Every set and clear operation in both stages goes through a write-one alias register, so software never needs a read-modify-write.

Software accesses the block through a simple port. Writes are synchronous. Reads are combinational from the current register state.

Top module: `irq_agg_top`

## Requirements
- R1: A high bit of `hw_evt` on a clock edge sets the matching flag, and the flag reads as set after that edge.
- R2: A write to address 1 sets each flag whose data bit is one. Zero data bits leave their flags unchanged.
- R3: A write to address 2 clears each flag whose data bit is one. Zero data bits leave their flags unchanged. If a hardware event and a clear hit the same flag in the same cycle, the flag stays set.
- R4: Address 3 is the per-flag enable register, read/write. A line's level is the OR of its flags ANDed with their enables. Levels read at address 10, with line i at bit i.
- R5: A high line level sets that line's pending bit one edge later. While the level stays high, it overrides a pending clear in the same cycle.
- R6: A write to address 5 sets pending bits where the data bit is one. A write to address 6 clears them. Pending bits read at address 4. Zero data bits have no effect.
- R7: Controller enables are set by a write to address 8 and cleared by a write to address 9, one data bit per line, and read at address 7. `core_req` is the pending bits ANDed with the controller enables.
- R8: A one on an `irq_ack` bit clears that line's pending bit. A high level or a pending-set in the same cycle wins over the acknowledge.
- R9: Reads of the alias addresses 1, 2, 5, 6, 8 and 9 return zero. A write to read-only address 0 changes no flag. Flags read at address 0.
- R10: A synchronous reset clears all flags, flag enables, pending bits and controller enables, and hardware events during reset are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_evt | input | NUM_LINES*FLAGS_PER_LINE | One-cycle hardware event pulses, one per flag |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | DATA_W | Register read data (combinational) |
| irq_ack | input | NUM_LINES | One-hot acknowledge from the core |
| core_req | output | NUM_LINES | Interrupt request vector to the core |

## Verification
The properties assume the following about the inputs:
- Only one register write happens per cycle, so a set alias and a clear alias never reach the same bank together.
- `irq_ack` is one-hot or zero.
- Reset is held from time zero for at least one edge.

The stimulus keeps to these assumptions. It issues at most one write per driven cycle, drives only single-bit acknowledges, and starts with reset asserted. It collides hardware events with clears, and acknowledges with high levels, only in the ways the requirements define.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int REG_ADDR_W   = 4;
    localparam int DEF_LINES    = 8;
    localparam int DEF_PER_LINE = 4;
    localparam int DEF_DATA_W   = 32;

    typedef enum logic [REG_ADDR_W-1:0] {
        RA_FLAGS     = 4'd0,
        RA_FLAG_SET  = 4'd1,
        RA_FLAG_CLR  = 4'd2,
        RA_FLAG_EN   = 4'd3,
        RA_PEND      = 4'd4,
        RA_PEND_SET  = 4'd5,
        RA_PEND_CLR  = 4'd6,
        RA_LINE_EN   = 4'd7,
        RA_LEN_SET   = 4'd8,
        RA_LEN_CLR   = 4'd9,
        RA_LEVEL     = 4'd10
    } reg_addr_e;

    typedef struct packed {
        logic flag_set;
        logic flag_clr;
        logic flag_en_wr;
        logic pend_set;
        logic pend_clr;
        logic len_set;
        logic len_clr;
    } wr_strobe_t;

    function automatic wr_strobe_t decode_write(input logic en, input logic [REG_ADDR_W-1:0] a);
        wr_strobe_t s;
        s            = '0;
        s.flag_set   = en && (a == RA_FLAG_SET);
        s.flag_clr   = en && (a == RA_FLAG_CLR);
        s.flag_en_wr = en && (a == RA_FLAG_EN);
        s.pend_set   = en && (a == RA_PEND_SET);
        s.pend_clr   = en && (a == RA_PEND_CLR);
        s.len_set    = en && (a == RA_LEN_SET);
        s.len_clr    = en && (a == RA_LEN_CLR);
        return s;
    endfunction

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int NUM_LINES      = 8,
    parameter int FLAGS_PER_LINE = 4,
    localparam int NF            = NUM_LINES * FLAGS_PER_LINE
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NF-1:0]        hw_evt,
    input  logic [NF-1:0]        set_mask,
    input  logic [NF-1:0]        clr_mask,
    input  logic                 en_wr,
    input  logic [NF-1:0]        en_data,
    output logic [NF-1:0]        flag_q,
    output logic [NF-1:0]        en_q,
    output logic [NUM_LINES-1:0] irq_line
);

    logic [NF-1:0] flag_d;

    // Hardware events and software sets dominate a same-cycle clear.
    always_comb flag_d = (flag_q & ~clr_mask) | set_mask | hw_evt;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= '0;
            en_q   <= '0;
        end else begin
            flag_q <= flag_d;
            if (en_wr) en_q <= en_data;
        end
    end

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        assign irq_line[l] = |(flag_q[l*FLAGS_PER_LINE +: FLAGS_PER_LINE] &
                               en_q[l*FLAGS_PER_LINE +: FLAGS_PER_LINE]);
    end

endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl #(
    parameter int NUM_LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] irq_line,
    input  logic [NUM_LINES-1:0] pset,
    input  logic [NUM_LINES-1:0] pclr,
    input  logic [NUM_LINES-1:0] eset,
    input  logic [NUM_LINES-1:0] eclr,
    input  logic [NUM_LINES-1:0] ack,
    output logic [NUM_LINES-1:0] pend_q,
    output logic [NUM_LINES-1:0] len_q,
    output logic [NUM_LINES-1:0] core_req
);

    logic [NUM_LINES-1:0] pend_d;
    logic [NUM_LINES-1:0] len_d;

    always_comb begin
        pend_d = (pend_q & ~pclr & ~ack) | pset | irq_line;
        len_d  = (len_q & ~eclr) | eset;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            len_q  <= '0;
        end else begin
            pend_q <= pend_d;
            len_q  <= len_d;
        end
    end

    assign core_req = pend_q & len_q;

endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
    import irq_agg_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int NF        = 32,
    parameter int DATA_W    = 32
) (
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] wr_addr,
    input  logic [REG_ADDR_W-1:0] rd_addr,
    input  logic [NF-1:0]         flag_q,
    input  logic [NF-1:0]         en_q,
    input  logic [NUM_LINES-1:0]  pend_q,
    input  logic [NUM_LINES-1:0]  len_q,
    input  logic [NUM_LINES-1:0]  irq_line,
    output wr_strobe_t            stb,
    output logic [DATA_W-1:0]     rd_data
);

    always_comb stb = decode_write(wr_en, wr_addr);

    // Alias and unmapped addresses read as zero.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            RA_FLAGS:   rd_data[NF-1:0]        = flag_q;
            RA_FLAG_EN: rd_data[NF-1:0]        = en_q;
            RA_PEND:    rd_data[NUM_LINES-1:0] = pend_q;
            RA_LINE_EN: rd_data[NUM_LINES-1:0] = len_q;
            RA_LEVEL:   rd_data[NUM_LINES-1:0] = irq_line;
            default:    rd_data                = '0;
        endcase
    end

endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
    import irq_agg_pkg::*;
#(
    parameter int NUM_LINES      = DEF_LINES,
    parameter int FLAGS_PER_LINE = DEF_PER_LINE,
    parameter int DATA_W         = DEF_DATA_W,
    localparam int NF            = NUM_LINES * FLAGS_PER_LINE
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NF-1:0]         hw_evt,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [REG_ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0]     rd_data,
    input  logic [NUM_LINES-1:0]  irq_ack,
    output logic [NUM_LINES-1:0]  core_req
);

    wr_strobe_t           stb;
    logic [NF-1:0]        flag_q;
    logic [NF-1:0]        en_q;
    logic [NUM_LINES-1:0] irq_line;
    logic [NUM_LINES-1:0] pend_q;
    logic [NUM_LINES-1:0] len_q;
    logic [NF-1:0]        fdata;
    logic [NUM_LINES-1:0] ldata;

    assign fdata = wr_data[NF-1:0];
    assign ldata = wr_data[NUM_LINES-1:0];

    irq_reg_port #(.NUM_LINES(NUM_LINES), .NF(NF), .DATA_W(DATA_W)) port_i (
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .rd_addr  (rd_addr),
        .flag_q   (flag_q),
        .en_q     (en_q),
        .pend_q   (pend_q),
        .len_q    (len_q),
        .irq_line (irq_line),
        .stb      (stb),
        .rd_data  (rd_data)
    );

    irq_flag_bank #(.NUM_LINES(NUM_LINES), .FLAGS_PER_LINE(FLAGS_PER_LINE)) bank_i (
        .clk      (clk),
        .rst      (rst),
        .hw_evt   (hw_evt),
        .set_mask (fdata & {NF{stb.flag_set}}),
        .clr_mask (fdata & {NF{stb.flag_clr}}),
        .en_wr    (stb.flag_en_wr),
        .en_data  (fdata),
        .flag_q   (flag_q),
        .en_q     (en_q),
        .irq_line (irq_line)
    );

    irq_pend_ctrl #(.NUM_LINES(NUM_LINES)) ctrl_i (
        .clk      (clk),
        .rst      (rst),
        .irq_line (irq_line),
        .pset     (ldata & {NUM_LINES{stb.pend_set}}),
        .pclr     (ldata & {NUM_LINES{stb.pend_clr}}),
        .eset     (ldata & {NUM_LINES{stb.len_set}}),
        .eclr     (ldata & {NUM_LINES{stb.len_clr}}),
        .ack      (irq_ack),
        .pend_q   (pend_q),
        .len_q    (len_q),
        .core_req (core_req)
    );

endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
    import irq_agg_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int NF        = 32,
    parameter int DATA_W    = 32
) (
    input logic                  clk,
    input logic                  rst,
    input logic [NF-1:0]         hw_evt,
    input logic                  wr_en,
    input logic [REG_ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0]     wr_data,
    input logic [NUM_LINES-1:0]  irq_ack,
    input logic [NF-1:0]         flag_q,
    input logic [NUM_LINES-1:0]  pend_q,
    input logic [NUM_LINES-1:0]  len_q,
    input logic [NUM_LINES-1:0]  irq_line,
    input logic [NUM_LINES-1:0]  core_req
);

    p_hw_sets_flag_r1: assert property (@(posedge clk) disable iff (rst)
        (|hw_evt) |=> ((flag_q & $past(hw_evt)) == $past(hw_evt)));

    p_clear_wins_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == RA_FLAG_CLR) |=>
            ((flag_q & $past(wr_data[NF-1:0] & ~hw_evt)) == '0));

    p_level_pends_r5: assert property (@(posedge clk) disable iff (rst)
        (|irq_line) |=> ((pend_q & $past(irq_line)) == $past(irq_line)));

    p_len_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == RA_LEN_CLR) |=>
            ((core_req & $past(wr_data[NUM_LINES-1:0])) == '0));

    p_ack_clears_r8: assert property (@(posedge clk) disable iff (rst)
        ((|irq_ack) && !(wr_en && wr_addr == RA_PEND_SET)) |=>
            ((pend_q & $past(irq_ack & ~irq_line)) == '0));

    p_ack_onehot_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(irq_ack));

    p_reset_clear_r10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (flag_q == '0 && pend_q == '0 && len_q == '0));

endmodule

bind irq_agg_top irq_agg_chk #(
    .NUM_LINES (NUM_LINES),
    .NF        (NUM_LINES * FLAGS_PER_LINE),
    .DATA_W    (DATA_W)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .hw_evt   (hw_evt),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .irq_ack  (irq_ack),
    .flag_q   (flag_q),
    .pend_q   (pend_q),
    .len_q    (len_q),
    .irq_line (irq_line),
    .core_req (core_req)
);

// File: tb/irq_agg_top_tb_top.sv
module irq_agg_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] hw_evt = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [7:0]  irq_ack = '0;
    logic [7:0]  core_req;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    irq_agg_top dut_i (
        .clk(clk), .rst(rst), .hw_evt(hw_evt), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .irq_ack(irq_ack), .core_req(core_req)
    );

    typedef struct packed {
        logic        wr;
        logic [3:0]  addr;
        logic [31:0] data;
        logic [31:0] hw;
        logic [3:0]  raddr;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    // One driven cycle per row, then a read of raddr compared with exp.
    localparam vec_t TBL [15] = '{
        '{1'b1, 4'd1,  32'h11,  32'h0,   4'd0,  32'h11,  8'd2},  // R2 set alias
        '{1'b0, 4'd0,  32'h0,   32'h100, 4'd0,  32'h111, 8'd1},  // R1 hw event
        '{1'b1, 4'd3,  32'h101, 32'h0,   4'd10, 32'h5,   8'd4},  // R4 levels
        '{1'b0, 4'd0,  32'h0,   32'h0,   4'd4,  32'h5,   8'd5},  // R5 level to pending
        '{1'b1, 4'd2,  32'h1,   32'h1,   4'd0,  32'h111, 8'd3},  // R3 event beats clear
        '{1'b1, 4'd2,  32'h110, 32'h0,   4'd0,  32'h1,   8'd3},  // R3 clear alias
        '{1'b1, 4'd6,  32'h4,   32'h0,   4'd4,  32'h1,   8'd6},  // R6 clear pending
        '{1'b1, 4'd6,  32'h1,   32'h0,   4'd4,  32'h1,   8'd5},  // R5 level overrides clear
        '{1'b1, 4'd3,  32'h0,   32'h0,   4'd10, 32'h0,   8'd4},  // R4 enables off
        '{1'b1, 4'd6,  32'h1,   32'h0,   4'd4,  32'h0,   8'd6},  // R6 clear pending
        '{1'b1, 4'd5,  32'h82,  32'h0,   4'd4,  32'h82,  8'd6},  // R6 set pending
        '{1'b1, 4'd8,  32'h3,   32'h0,   4'd7,  32'h3,   8'd7},  // R7 set enable
        '{1'b1, 4'd9,  32'h1,   32'h0,   4'd7,  32'h2,   8'd7},  // R7 clear enable
        '{1'b1, 4'd0,  32'hFFFF,32'h0,   4'd0,  32'h1,   8'd9},  // R9 read-only write
        '{1'b0, 4'd0,  32'h0,   32'h0,   4'd1,  32'h0,   8'd9}   // R9 alias reads zero
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic w, input logic [3:0] a, input logic [31:0] d,
                         input logic [31:0] h, input logic [7:0] k);
        @(negedge clk);
        wr_en = w; wr_addr = a; wr_data = d; hw_evt = h; irq_ack = k;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = '0; wr_data = '0; hw_evt = '0; irq_ack = '0;
    endtask

    task automatic read_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
        rd_addr = a;
        #1;
        check(tag, rd_data, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        read_chk("R10 reset flags", 4'd0, 32'h0);
        read_chk("R10 reset pend", 4'd4, 32'h0);
        check("R10 reset core_req", {24'h0, core_req}, 32'h0);

        for (int i = 0; i < 15; i++) begin
            drive(TBL[i].wr, TBL[i].addr, TBL[i].data, TBL[i].hw, 8'h0);
            read_chk($sformatf("R%0d row %0d", TBL[i].req, i), TBL[i].raddr, TBL[i].exp);
        end

        // R7: pending 0x82 with controller enable 0x02
        check("R7 core_req gated", {24'h0, core_req}, 32'h2);
        // R8: acknowledge clears line 1
        drive(1'b0, 4'd0, 32'h0, 32'h0, 8'h02);
        read_chk("R8 ack clears", 4'd4, 32'h80);
        check("R8 core_req after ack", {24'h0, core_req}, 32'h0);
        // R8: held level beats acknowledge
        drive(1'b1, 4'd3, 32'h1, 32'h0, 8'h00);
        drive(1'b0, 4'd0, 32'h0, 32'h0, 8'h00);
        drive(1'b0, 4'd0, 32'h0, 32'h0, 8'h01);
        read_chk("R8 level beats ack", 4'd4, 32'h81);
        drive(1'b1, 4'd8, 32'h1, 32'h0, 8'h00);
        check("R7 core_req enabled", {24'h0, core_req}, 32'h1);

        // R10: reset with events present
        @(negedge clk);
        rst = 1'b1; hw_evt = '1;
        repeat (2) @(negedge clk);
        rst = 1'b0; hw_evt = '0;
        read_chk("R10 flags after reset", 4'd0, 32'h0);
        read_chk("R10 enables after reset", 4'd3, 32'h0);
        read_chk("R10 pend after reset", 4'd4, 32'h0);
        read_chk("R10 line enables after reset", 4'd7, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule